// File: doc/BRIEF.md
# Serial DAC Input Control Logic

This block is the digital front end of a 14-bit voltage-output DAC. A host writes 16-bit frames over a three-wire serial link: an active-low frame select, a serial clock and a data line. The block samples the serial inputs on its own system clock and treats a high-to-low step of the serial clock as one bit. When a frame completes, it loads a 14-bit code register and a 2-bit output-mode register. A frame that is cut short is discarded and leaves both registers unchanged.

The outputs drive the analog part of the converter. These are the held DAC code, an enable for the output amplifier, and three mutually exclusive termination selects that are used while the output is powered down. A one-cycle strobe marks every register load. Power-on reset is modelled as a synchronous active-high reset. The serial inputs are assumed to be already synchronous to `clk`.

Top module: `serdac_ctrl`

## Requirements
- R1: During and right after reset, `dac_code` is 0, the mode is normal, `amp_en` is 1, all three termination selects are 0 and `upd_stb` is 0.
- R2: A serial clock falling edge is a cycle where `sclk` was sampled high at one rising `clk` edge and low at the next. Data bits are taken from `sdin` at those edges while `sync_n` is low, MSB first. Frame bit 15 and bit 14 form the mode (bit 15 is the upper mode bit), and bits 13:0 form the code.
- R3: If the 16th falling edge of a frame is seen at rising `clk` edge E, then `dac_code`, the amplifier enable and the selects take the new values at edge E+1. At that same edge `upd_stb` goes high for exactly one cycle.
- R4: If `sync_n` goes high before the 16th falling edge, the code and the mode are unchanged and no strobe is issued. The next frame is assembled from fresh bits only.
- R5: Mode 00 sets `amp_en`=1 with no select. Mode 01 asserts only `term_1k`, mode 10 asserts only `term_100k`, and mode 11 asserts only `term_hiz`. Exactly one of the four outputs is high at all times.
- R6: The code loaded with a power-down mode stays on `dac_code` while the output is powered down.
- R7: After the 16th edge, further falling edges are ignored while `sync_n` stays low. Another frame starts only after `sync_n` has been high and falls again.
- R8: Serial clock falling edges while `sync_n` is high have no effect.
- R9: If `sync_n` is already low when reset ends, edges are ignored until `sync_n` has been high once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| sync_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; bits taken on its falling edge |
| sdin | input | 1 | Serial data, MSB first |
| dac_code | output | CODE_W | Held DAC code |
| amp_en | output | 1 | Output amplifier enable (normal mode) |
| term_1k | output | 1 | Power-down: 1 kΩ to ground |
| term_100k | output | 1 | Power-down: 100 kΩ to ground |
| term_hiz | output | 1 | Power-down: output three-stated |
| upd_stb | output | 1 | One-cycle pulse on every register load |

## Verification
The bench targets frames that are interrupted after 10 bits. A design that failed to clear its partial shift state would then load a mixture of old and new bits on the following frame. It also sends extra clock edges after a completed frame with the select still low, where a non-saturating counter would start a phantom second frame and give a second strobe. Clock edges with the select high, and a select held low through reset, are exercised to catch front ends that accept bits without a fresh frame start. Each mode is cycled through with distinct codes to catch swapped mode bits or a code cleared on power-down.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
   localparam int MODE_W = 2;
   localparam int N_TERM = 3;

   typedef enum logic [MODE_W-1:0] {
      OM_DRIVE     = 2'd0,
      OM_SINK_LOW  = 2'd1,
      OM_SINK_HIGH = 2'd2,
      OM_FLOAT     = 2'd3
   } out_mode_e;
endpackage

// File: rtl/serdac_sclk_edge.sv
module serdac_sclk_edge (
   input  logic clk,
   input  logic rst,
   input  logic sclk_i,
   output logic fall_o
);
   logic sclk_q;

   always_ff @(posedge clk) begin
      if (rst) sclk_q <= 1'b0;
      else     sclk_q <= sclk_i;
   end

   // high at the previous sample, low now
   assign fall_o = sclk_q & ~sclk_i;
endmodule

// File: rtl/serdac_frame.sv
module serdac_frame #(
   parameter int FRAME_W = 16,
   parameter int CNT_W   = 5
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               sync_n,
   input  logic               fall,
   input  logic               sdin,
   output logic               load_o,
   output logic [FRAME_W-1:0] word_o
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

   logic [CNT_W-1:0]   cnt_q;
   logic [FRAME_W-1:0] sr_q;
   logic               load_q;

   // cnt_q == FULL means locked: wait for sync_n high before accepting bits
   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= FULL;
         sr_q   <= '0;
         load_q <= 1'b0;
      end else begin
         load_q <= 1'b0;
         if (sync_n) begin
            cnt_q <= '0;
            sr_q  <= '0;
         end else if (fall && (cnt_q < FULL)) begin
            sr_q  <= {sr_q[FRAME_W-2:0], sdin};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) load_q <= 1'b1;
         end
      end
   end

   assign load_o = load_q;
   assign word_o = sr_q;
endmodule

// File: rtl/serdac_term.sv
module serdac_term
   import serdac_pkg::*;
(
   input  out_mode_e          mode,
   output logic               amp_en,
   output logic [N_TERM-1:0]  term
);
   assign amp_en = (mode == OM_DRIVE);

   for (genvar g = 0; g < N_TERM; g++) begin : g_sel
      assign term[g] = (mode == out_mode_e'(g + 1));
   end
endmodule

// File: rtl/serdac_ctrl.sv
module serdac_ctrl
   import serdac_pkg::*;
#(
   parameter int CODE_W = 14
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sync_n,
   input  logic              sclk,
   input  logic              sdin,
   output logic [CODE_W-1:0] dac_code,
   output logic              amp_en,
   output logic              term_1k,
   output logic              term_100k,
   output logic              term_hiz,
   output logic              upd_stb
);
   localparam int FRAME_W = CODE_W + MODE_W;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   if (CODE_W < 2 || CODE_W > 24) begin : g_bad_code
      $error("serdac_ctrl: CODE_W out of range");
   end
   if (N_TERM != (1 << MODE_W) - 1) begin : g_bad_term
      $error("serdac_ctrl: termination count must match mode space");
   end

   logic               fall;
   logic               load;
   logic [FRAME_W-1:0] word;
   logic [N_TERM-1:0]  term;

   logic [CODE_W-1:0]  code_q;
   out_mode_e          mode_q;
   logic               upd_q;

   serdac_sclk_edge u_edge (
      .clk    (clk),
      .rst    (rst),
      .sclk_i (sclk),
      .fall_o (fall)
   );

   serdac_frame #(
      .FRAME_W (FRAME_W),
      .CNT_W   (CNT_W)
   ) u_frame (
      .clk    (clk),
      .rst    (rst),
      .sync_n (sync_n),
      .fall   (fall),
      .sdin   (sdin),
      .load_o (load),
      .word_o (word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q <= '0;
         mode_q <= OM_DRIVE;
         upd_q  <= 1'b0;
      end else begin
         upd_q <= load;
         if (load) begin
            code_q <= word[CODE_W-1:0];
            mode_q <= out_mode_e'(word[FRAME_W-1:CODE_W]);
         end
      end
   end

   serdac_term u_term (
      .mode   (mode_q),
      .amp_en (amp_en),
      .term   (term)
   );

   assign dac_code  = code_q;
   assign term_1k   = term[0];
   assign term_100k = term[1];
   assign term_hiz  = term[2];
   assign upd_stb   = upd_q;
endmodule

// File: rtl/serdac_ctrl_chk.sv
module serdac_ctrl_chk #(
   parameter int CODE_W = 14
) (
   input logic              clk,
   input logic              rst,
   input logic              sync_n,
   input logic [CODE_W-1:0] dac_code,
   input logic              amp_en,
   input logic              term_1k,
   input logic              term_100k,
   input logic              term_hiz,
   input logic              upd_stb
);
   AST_ONE_OUTPUT_STATE: assert property (@(posedge clk) disable iff (rst)
      $countones({amp_en, term_1k, term_100k, term_hiz}) == 1); // R5

   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
      upd_stb |=> !upd_stb); // R3

   AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
      !upd_stb |-> $stable(dac_code)); // R4

   AST_IDLE_NO_STB: assert property (@(posedge clk) disable iff (rst)
      ($past(sync_n, 2) && $past(sync_n) && sync_n) |-> !upd_stb); // R8

   AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (dac_code == '0 && amp_en && !upd_stb)); // R1
endmodule

bind serdac_ctrl serdac_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .sync_n    (sync_n),
   .dac_code  (dac_code),
   .amp_en    (amp_en),
   .term_1k   (term_1k),
   .term_100k (term_100k),
   .term_hiz  (term_hiz),
   .upd_stb   (upd_stb)
);

// File: tb/tb_serdac_ctrl.sv
module tb_serdac_ctrl;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sync_n = 1'b1;
   logic        sclk = 1'b1;
   logic        sdin = 1'b0;
   logic [13:0] dac_code;
   logic        amp_en, term_1k, term_100k, term_hiz, upd_stb;

   int n_chk = 0;
   int n_fail = 0;
   int n_upd = 0;

   always #(CLK_P/2) clk = ~clk;

   serdac_ctrl dut (
      .clk(clk), .rst(rst), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
      .dac_code(dac_code), .amp_en(amp_en), .term_1k(term_1k),
      .term_100k(term_100k), .term_hiz(term_hiz), .upd_stb(upd_stb)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural reference: integers and a bit queue
   int       m_cnt;
   bit       m_bits[$];
   bit       m_load;
   int       m_word;
   bit       m_prev;
   int       e_dac;
   int       e_mode;
   bit       e_upd;

   always @(posedge clk) begin
      if (rst) begin
         m_cnt = 16; m_bits = {}; m_load = 0; m_word = 0; m_prev = 0;
         e_dac = 0; e_mode = 0; e_upd = 0;
      end else begin
         e_upd = m_load;
         if (m_load) begin
            e_dac  = m_word % 16384;
            e_mode = m_word / 16384;
         end
         m_load = 0;
         if (sync_n) begin
            m_cnt = 0; m_bits = {};
         end else if (m_prev && !sclk && m_cnt < 16) begin
            m_bits.push_back(sdin);
            m_cnt++;
            if (m_cnt == 16) begin
               m_word = 0;
               foreach (m_bits[i]) m_word = m_word * 2 + int'(m_bits[i]);
               m_load = 1;
            end
         end
         m_prev = sclk;
      end
   end

   always @(negedge clk) begin
      if (!rst) begin
         if (upd_stb) n_upd++;
         chk(int'(dac_code) == e_dac, "R3 model code", int'(dac_code), e_dac);
         chk(upd_stb == e_upd, "R3 model strobe", int'(upd_stb), int'(e_upd));
         chk({amp_en, term_1k, term_100k, term_hiz} ==
             {e_mode == 0, e_mode == 1, e_mode == 2, e_mode == 3},
             "R5 model mode", int'({amp_en, term_1k, term_100k, term_hiz}), e_mode);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic bits(input logic [15:0] w, input int n);
      for (int i = 0; i < n; i++) begin
         sdin = w[15-i]; sclk = 1'b1; cyc(2);
         sclk = 1'b0; cyc(2);
      end
      sclk = 1'b1; cyc(1);
   endtask

   task automatic frame(input logic [15:0] w);
      sync_n = 1'b0; cyc(2);
      bits(w, 16);
      sync_n = 1'b1; cyc(3);
   endtask

   task automatic look;
      @(negedge clk);
   endtask

   task automatic chk_out(input string req, input int code, input int mode);
      look();
      chk(int'(dac_code) == code, req, int'(dac_code), code);
      chk({amp_en, term_1k, term_100k, term_hiz} ==
          {mode == 0, mode == 1, mode == 2, mode == 3}, req,
          int'({amp_en, term_1k, term_100k, term_hiz}), mode);
   endtask

   initial begin
      int u0;
      // R9: select held low through reset
      sync_n = 1'b0;
      cyc(3);
      rst = 1'b0;
      look();
      chk(dac_code == 0 && amp_en && !term_1k && !term_100k && !term_hiz && !upd_stb,
          "R1 reset state", int'(dac_code), 0);
      cyc(1);
      u0 = n_upd;
      bits(16'h3FFF, 16);
      cyc(2);
      chk_out("R9 locked after reset", 0, 0);
      chk(n_upd == u0, "R9 no strobe", n_upd - u0, 0);
      sync_n = 1'b1; cyc(3);

      // R2/R3: normal frame
      u0 = n_upd;
      frame(16'h1234);
      chk_out("R2 normal frame", 16'h1234, 0);
      chk(n_upd == u0 + 1, "R3 one strobe", n_upd - u0, 1);

      // R5: each power-down mode, R6 code retained
      frame({2'b01, 14'h3FFF});
      chk_out("R5 mode 01", 16'h3FFF, 1);
      frame({2'b10, 14'h0001});
      chk_out("R5 mode 10", 1, 2);
      frame({2'b11, 14'h2AAA});
      chk_out("R6 code kept in float", 16'h2AAA, 3);
      cyc(20);
      chk_out("R6 code still held", 16'h2AAA, 3);
      frame({2'b00, 14'h2AAA});
      chk_out("R6 return to normal", 16'h2AAA, 0);

      // R4: interrupted frame
      u0 = n_upd;
      sync_n = 1'b0; cyc(2);
      bits(16'hFFFF, 10);
      sync_n = 1'b1; cyc(3);
      chk_out("R4 interrupt no change", 16'h2AAA, 0);
      chk(n_upd == u0, "R4 no strobe", n_upd - u0, 0);
      frame(16'h0005);
      chk_out("R4 fresh frame after interrupt", 5, 0);

      // R7: extra edges with select still low
      u0 = n_upd;
      sync_n = 1'b0; cyc(2);
      bits({2'b10, 14'h1111}, 16);
      cyc(2);
      bits(16'hFFFF, 16);
      cyc(2);
      chk_out("R7 extra edges ignored", 16'h1111, 2);
      chk(n_upd == u0 + 1, "R7 single strobe", n_upd - u0, 1);
      sync_n = 1'b1; cyc(3);

      // R8: edges while select is high
      u0 = n_upd;
      bits(16'h0000, 16);
      cyc(2);
      chk_out("R8 idle edges ignored", 16'h1111, 2);
      chk(n_upd == u0, "R8 no strobe", n_upd - u0, 0);

      frame(16'hC000);
      chk_out("R5 zero code float", 0, 3);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule